// File: doc/BRIEF.md
# Result FIFO with Occupancy and Error Status

This block is a single-clock first-in first-out buffer for conversion result words coming out of a trigger unit. The producer presents a word with a valid strobe. The consumer asks for the oldest word with a request strobe and receives it on a registered data output one cycle later. Four status conditions are kept beside the storage:
- full, when the buffer holds its maximum number of words;
- empty, when it holds no words;
- over-threshold, when the occupancy is above a programmable level;
- overrun, a sticky error that records a push made while the buffer had no room.

All four conditions are combined onto one interrupt request line. A second request line serves a DMA engine. When the DMA enable input is set, this line follows only the over-threshold condition, so the engine can drain the buffer in bursts. When the enable is clear, it mirrors the interrupt line. The threshold is held in a register loaded through a write strobe. The overrun error is cleared by writing a one through its clear port.

Top module: `res_fifo`

## Requirements
- R1: `full` is 1 exactly when the buffer holds DEPTH words (8 by default).
- R2: `empty` is 1 exactly when the buffer holds zero words.
- R3: `thr_over` is 1 exactly when the stored word count is strictly greater than the threshold register. The register loads `thr_wdata` on a cycle with `thr_we` high, and it resets to THR_INIT (4 by default).
- R4: A push made while `full` is 1 and without a pop in the same cycle is discarded. It leaves the stored words unchanged and sets `overrun` at the next clock edge.
- R5: `overrun` stays at 1 until a cycle with `ovr_clr_we` high and `ovr_clr_data` equal to 1. In such a cycle it clears, unless a new overrun occurs in the same cycle, in which case it stays set. A clear write with `ovr_clr_data` equal to 0 has no effect.
- R6: A push together with a pop while full is a normal transfer. The count stays at DEPTH and `overrun` is not raised.
- R7: A pop request while empty is ignored. The count stays 0 and `pop_data` keeps its previous value. A push in the same cycle is still accepted.
- R8: One cycle after an accepted pop, `pop_data` shows the oldest stored word. Words leave in the order they were pushed.
- R9: `irq` is the OR of `full`, `empty`, `thr_over` and `overrun`.
- R10: `dma_req` equals `thr_over` when `dma_en` is 1, and equals `irq` when `dma_en` is 0.
- R11: After reset the buffer is empty, `overrun` is 0, `full` is 0 and `pop_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_vld | input | 1 | Push a word this cycle |
| push_data | input | DW | Word to push |
| pop_req | input | 1 | Pop the oldest word this cycle |
| pop_data | output | DW | Registered popped word |
| thr_we | input | 1 | Load the threshold register |
| thr_wdata | input | CW | New threshold value |
| ovr_clr_we | input | 1 | Write strobe for the overrun clear |
| ovr_clr_data | input | 1 | Written bit; 1 clears overrun, 0 does nothing |
| dma_en | input | 1 | Route the threshold condition to dma_req |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| thr_over | output | 1 | Occupancy above threshold |
| overrun | output | 1 | Sticky push-while-full error |
| irq | output | 1 | OR of all status conditions |
| dma_req | output | 1 | DMA request line |

## Verification
The buffer is driven through several patterns:
- Pure pushes from empty to full. These walk the count across the threshold and separate a strict comparison from a non-strict one at occupancy 4.
- Mixed push/pop cycles at mid occupancy and at full. These separate a true transfer from a rejected write.
- A lone push at full. This shows the overrun flag and that no word was stored, because the drained sequence lacks the rejected word.
- Pops on an empty buffer, alone and together with a push. These separate an ignored read from a corrupted count or data output.

Clear writes of 0 and of 1, threshold reloads around the live count, and both settings of the DMA enable then pin down the error and request logic.

// File: rtl/res_fifo_pkg.sv
package res_fifo_pkg;

  // Occupancy after one cycle with the given accepted write/read.
  function automatic int unsigned f_next_count(int unsigned cnt, logic wr, logic rd);
    int unsigned n;
    n = cnt;
    if (wr && !rd) n = cnt + 1;
    else if (rd && !wr) n = cnt - 1;
    return n;
  endfunction

  // Pointer increment with wrap at the last slot.
  function automatic int unsigned f_ptr_inc(int unsigned ptr, int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // Threshold comparison: strictly greater.
  function automatic logic f_above(int unsigned cnt, int unsigned thr);
    return cnt > thr;
  endfunction

endpackage

// File: rtl/res_fifo_mem.sv
module res_fifo_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_ptr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_ptr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0]    slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;

  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = wr_en && (wr_ptr == AW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= slot_q[rd_ptr];
  end

endmodule

// File: rtl/res_fifo_ctrl.sv
module res_fifo_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_vld,
  input  logic          pop_req,
  output logic          wr_ev,
  output logic          rd_ev,
  output logic          ovr_ev,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count
);
  import res_fifo_pkg::*;

  logic at_full, at_empty;

  assign at_full  = (count == CW'(DEPTH));
  assign at_empty = (count == '0);

  // Events brought out as named wires
  assign rd_ev  = pop_req && !at_empty;
  assign wr_ev  = push_vld && (!at_full || pop_req);
  assign ovr_ev = push_vld && at_full && !pop_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ev) wr_ptr <= AW'(f_ptr_inc(int'(wr_ptr), DEPTH));
      if (rd_ev) rd_ptr <= AW'(f_ptr_inc(int'(rd_ptr), DEPTH));
      count <= CW'(f_next_count(int'(count), wr_ev, rd_ev));
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r4_reject_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> $stable(count) && $stable(wr_ptr));

  a_r6_full_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && pop_req && at_full) |=> (count == CW'(DEPTH)));

  a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && at_empty && !push_vld) |=> (count == '0) && $stable(rd_ptr));

endmodule

// File: rtl/res_fifo_flags.sv
module res_fifo_flags #(
  parameter int DEPTH    = 8,
  parameter int THR_INIT = 4,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          ovr_ev,
  input  logic          thr_we,
  input  logic [CW-1:0] thr_wdata,
  input  logic          ovr_clr_we,
  input  logic          ovr_clr_data,
  input  logic          dma_en,
  output logic          full,
  output logic          empty,
  output logic          thr_over,
  output logic          overrun,
  output logic          irq,
  output logic          dma_req
);
  import res_fifo_pkg::*;

  logic [CW-1:0] thr_q;
  logic          clr_hit;

  assign clr_hit = ovr_clr_we && ovr_clr_data;

  always_ff @(posedge clk) begin
    if (!rst_n)      thr_q <= CW'(THR_INIT);
    else if (thr_we) thr_q <= thr_wdata;
  end

  // A new overrun wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (ovr_ev)  overrun <= 1'b1;
    else if (clr_hit) overrun <= 1'b0;
  end

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign thr_over = f_above(int'(count), int'(thr_q));
  assign irq      = full | empty | thr_over | overrun;
  assign dma_req  = dma_en ? thr_over : irq;

  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> overrun);

  a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !ovr_ev) |=> !overrun);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_hit) |=> overrun);

  a_r1_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

endmodule

// File: rtl/res_fifo.sv
module res_fifo #(
  parameter int DW       = 16,
  parameter int DEPTH    = 8,
  parameter int THR_INIT = 4,
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_vld,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  input  logic          thr_we,
  input  logic [CW-1:0] thr_wdata,
  input  logic          ovr_clr_we,
  input  logic          ovr_clr_data,
  input  logic          dma_en,
  output logic          full,
  output logic          empty,
  output logic          thr_over,
  output logic          overrun,
  output logic          irq,
  output logic          dma_req
);

  logic          wr_ev, rd_ev, ovr_ev;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  res_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .pop_req(pop_req),
    .wr_ev(wr_ev), .rd_ev(rd_ev), .ovr_ev(ovr_ev),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count)
  );

  res_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ev), .wr_ptr(wr_ptr),
    .wr_data(push_data), .rd_en(rd_ev), .rd_ptr(rd_ptr), .rd_data(pop_data)
  );

  res_fifo_flags #(.DEPTH(DEPTH), .THR_INIT(THR_INIT)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .ovr_ev(ovr_ev),
    .thr_we(thr_we), .thr_wdata(thr_wdata),
    .ovr_clr_we(ovr_clr_we), .ovr_clr_data(ovr_clr_data), .dma_en(dma_en),
    .full(full), .empty(empty), .thr_over(thr_over), .overrun(overrun),
    .irq(irq), .dma_req(dma_req)
  );

  a_r8_pop_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(pop_data));

endmodule

// File: tb/res_fifo_tb.sv
`timescale 1ns/100ps
module res_fifo_tb;

  localparam int DW = 16;
  localparam int DEPTH = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_vld = 0, pop_req = 0, thr_we = 0, ovr_clr_we = 0, ovr_clr_data = 0, dma_en = 0;
  logic [DW-1:0] push_data = '0;
  logic [CW-1:0] thr_wdata = '0;
  logic [DW-1:0] pop_data;
  logic full, empty, thr_over, overrun, irq, dma_req;

  int checks = 0, failures = 0;
  bit done = 0;
  int thr_m = 4;
  logic [DW-1:0] last_out = '0;
  logic [DW-1:0] q[$];

  always #2.5 clk = ~clk;

  res_fifo #(.DW(DW), .DEPTH(DEPTH), .THR_INIT(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
    .ovr_clr_we(ovr_clr_we), .ovr_clr_data(ovr_clr_data), .dma_en(dma_en),
    .full(full), .empty(empty), .thr_over(thr_over), .overrun(overrun),
    .irq(irq), .dma_req(dma_req)
  );

  typedef struct packed {
    logic        psh;
    logic        pop;
    logic [15:0] dat;
    logic [3:0]  cnt;
    logic        ovr;
  } vec_t;

  localparam vec_t VECS [15] = '{
    '{1'b1, 1'b0, 16'h00A1, 4'd1, 1'b0},
    '{1'b1, 1'b0, 16'h00A2, 4'd2, 1'b0},
    '{1'b1, 1'b0, 16'h00A3, 4'd3, 1'b0},
    '{1'b1, 1'b0, 16'h00A4, 4'd4, 1'b0},
    '{1'b1, 1'b0, 16'h00A5, 4'd5, 1'b0},
    '{1'b1, 1'b1, 16'h00A6, 4'd5, 1'b0},
    '{1'b0, 1'b1, 16'h0000, 4'd4, 1'b0},
    '{1'b1, 1'b0, 16'h00A7, 4'd5, 1'b0},
    '{1'b1, 1'b0, 16'h00A8, 4'd6, 1'b0},
    '{1'b1, 1'b0, 16'h00A9, 4'd7, 1'b0},
    '{1'b1, 1'b0, 16'h00AA, 4'd8, 1'b0},
    '{1'b1, 1'b1, 16'h00AB, 4'd8, 1'b0},
    '{1'b1, 1'b0, 16'h00EE, 4'd8, 1'b1},
    '{1'b0, 1'b1, 16'h0000, 4'd7, 1'b1},
    '{1'b0, 1'b0, 16'h0000, 4'd7, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle, update the model, sample 1 ns after the edge.
  task automatic step(logic p, logic r, logic [DW-1:0] d);
    bit popped;
    @(negedge clk);
    push_vld = p; pop_req = r; push_data = d;
    popped = r && (q.size() > 0);
    @(posedge clk); #1;
    if (popped) last_out = q.pop_front();
    if (p && (q.size() < DEPTH || popped)) q.push_back(d);
    push_vld = 0; pop_req = 0;
  endtask

  task automatic check_flags(string tag);
    int n;
    n = q.size();
    check({tag, " R1 full"},  32'(full),  32'(n == DEPTH));
    check({tag, " R2 empty"}, 32'(empty), 32'(n == 0));
    check({tag, " R3 thr"},   32'(thr_over), 32'(n > thr_m));
    check({tag, " R9 irq"},   32'(irq), 32'((n == DEPTH) || (n == 0) || (n > thr_m) || overrun));
    check({tag, " R10 dma"},  32'(dma_req), dma_en ? 32'(n > thr_m) : 32'(irq));
  endtask

  task automatic clr_write(logic b);
    @(negedge clk);
    ovr_clr_we = 1; ovr_clr_data = b;
    @(posedge clk); #1;
    ovr_clr_we = 0; ovr_clr_data = 0;
  endtask

  task automatic thr_write(int v);
    @(negedge clk);
    thr_we = 1; thr_wdata = CW'(v);
    @(posedge clk); #1;
    thr_we = 0; thr_m = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state, observed while reset is held
    check("R11 empty", 32'(empty), 1);
    check("R11 full", 32'(full), 0);
    check("R11 overrun", 32'(overrun), 0);
    check("R11 pop_data", 32'(pop_data), 0);
    check("R9 irq at reset", 32'(irq), 1);
    @(negedge clk); rst_n = 1;

    // Table walk: R1 R2 R3 R4 R6 R8
    foreach (VECS[i]) begin
      step(VECS[i].psh, VECS[i].pop, VECS[i].dat);
      check($sformatf("vec%0d count R1/R2", i), 32'(q.size()), 32'(VECS[i].cnt));
      check($sformatf("vec%0d R4/R6 overrun", i), 32'(overrun), 32'(VECS[i].ovr));
      check_flags($sformatf("vec%0d", i));
      if (VECS[i].pop) check($sformatf("vec%0d R8 pop_data", i), 32'(pop_data), 32'(last_out));
    end

    // R5: writing 0 has no effect, writing 1 clears
    clr_write(1'b0);
    check("R5 zero write keeps overrun", 32'(overrun), 1);
    clr_write(1'b1);
    check("R5 one write clears overrun", 32'(overrun), 0);

    // R3: reprogram threshold around count 7
    thr_write(6);
    check("R3 thr 6 count 7", 32'(thr_over), 1);
    thr_write(7);
    check("R3 thr 7 count 7", 32'(thr_over), 0);

    // R10 with dma_en set
    @(negedge clk); dma_en = 1;
    #1;
    check("R10 dma follows thr (low)", 32'(dma_req), 0);
    check("R9 irq low mid occupancy", 32'(irq), 0);
    step(1, 0, 16'h00B1);
    check_flags("fill8");
    check("R10 dma follows thr (high)", 32'(dma_req), 1);
    @(negedge clk); dma_en = 0;

    // R5: overrun and clear in the same cycle, set wins
    @(negedge clk);
    push_vld = 1; push_data = 16'h00EF; ovr_clr_we = 1; ovr_clr_data = 1;
    @(posedge clk); #1;
    push_vld = 0; ovr_clr_we = 0; ovr_clr_data = 0;
    check("R5 set wins over clear", 32'(overrun), 1);
    clr_write(1'b1);

    // R8: drain, checking FIFO order (rejected words absent, R4)
    for (int k = 0; k < DEPTH; k++) begin
      step(0, 1, '0);
      check($sformatf("drain%0d R8/R4 order", k), 32'(pop_data), 32'(last_out));
    end
    check_flags("drained");

    // R7: pop while empty
    step(0, 1, '0);
    check("R7 pop_data held", 32'(pop_data), 32'(last_out));
    check("R7 still empty", 32'(empty), 1);

    // R7: push and pop together while empty, push accepted
    step(1, 1, 16'h00C3);
    check("R7 push accepted with pop on empty", 32'(empty), 0);
    check("R7 pop_data unchanged", 32'(pop_data), 32'(last_out));
    step(0, 1, '0);
    check("R8 single word out", 32'(pop_data), 32'h00C3);
    check_flags("end");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule